// File: doc/BRIEF.md
# Oversampled Serial Receiver with Noise Detection

This block is the receive front end of an asynchronous serial link. The raw line first passes through a two-flop synchronizer. After that it is sampled once per enable tick, and the tick runs at sixteen times the bit rate. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit.

A start bit is accepted only at a falling edge that follows a clean idle history. Each bit is then resolved by a majority vote over three central samples. Any disagreement in those samples marks the frame as noisy. A start bit whose central vote comes out high is treated as a glitch and dropped. The stop bit is voted in the same way, and a low result marks a framing error.

The received byte is delivered with a one-cycle valid strobe. The noise and framing flags are delivered at the same moment and stay steady until the next start bit is accepted. The tick source, parity, buffering and any software access live outside this block.

Top module: `serial_os_rx`

## Requirements
- R1: A frame is one start bit (0), 8 data bits with the least significant bit first, and one stop bit (1). Each bit spans 16 ticks, numbered 1 to 16, and the first start-bit tick is the one at which the falling edge is accepted. On the strobe, `data_o` carries the received byte, and it changes at no other time.
- R2: A start bit is accepted only at a tick whose sample is 0 while the three preceding tick samples were all 1. After reset those three history samples count as 0, so the line must be seen high for three ticks before any frame can begin.
- R3: In an accepted start bit, a 1 at sample 3, 5 or 7 sets the noise flag of that frame.
- R4: In an accepted start bit, a 1 at any of samples 8, 9 or 10 sets the noise flag of that frame.
- R5: Each data bit takes the majority value of its samples 8, 9 and 10.
- R6: In a data bit, samples 8, 9 and 10 that are not all equal set the noise flag of the frame.
- R7: If the majority of start-bit samples 8, 9 and 10 is 1, the receiver returns to idle and issues no strobe for that attempt.
- R8: The stop bit is voted over samples 8, 9 and 10 like a data bit. A disagreement sets the noise flag. A 0 result sets `frm_err_o`, which is delivered together with the byte.
- R9: `valid_o` is a single-cycle pulse in the clock cycle after the tick that carries stop-bit sample 10. `noise_o` and `frm_err_o` take their frame values in that same cycle, hold them, and clear on the tick that accepts the next start bit.
- R10: Frames whose bit period differs from the nominal one by up to 3 percent, in either direction, are received with the correct byte and with no noise or framing flag.
- R11: During and right after reset, `data_o` is 0 and `valid_o`, `noise_o` and `frm_err_o` are 0.
- R12: The line is sampled only on clock edges where `tick_i` is high, and the strobe is issued only in the cycle after such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle sample enable, sixteen per bit period |
| rxd_i | input | 1 | Raw asynchronous receive line, idle high |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe marking a new byte |
| noise_o | output | 1 | Sample disagreement seen in the delivered frame |
| frm_err_o | output | 1 | Stop bit of the delivered frame voted low |

## Verification
A sample counter that is one tick off moves the voting window. Single-sample disturbances placed at the window edges then show up on the noise flag, or as a wrong bit in the byte, on the very frame that is affected. A history register that is not cleared, or that tracks the wrong samples, lets a short pulse after reset start a phantom frame. That shows up as an unexpected strobe about ten bit periods later. A sticky flag that does not clear, or a glitch start that is not dropped, shows up as a wrong flag or an extra or missing strobe on the next frame delivered.

// File: rtl/serial_os_rx_pkg.sv
package serial_os_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // sample numbers that carry the central vote of every bit
  localparam int unsigned VOTE_A = 8;
  localparam int unsigned VOTE_B = 9;
  localparam int unsigned VOTE_C = 10;

  // early start-bit samples that must already read low
  localparam int unsigned EARLY_A = 3;
  localparam int unsigned EARLY_B = 5;
  localparam int unsigned EARLY_C = 7;

endpackage

// File: rtl/rx_sync2.sv
module rx_sync2 #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rx_edge_qual.sv
module rx_edge_qual #(
  parameter int unsigned HIST = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic smp_i,
  output logic start_ok_o
);

  logic [HIST-1:0] hist_q;
  logic [HIST-1:0] hist_d;

  // history of the last HIST tick samples, updated on every tick
  always_comb begin
    hist_d = hist_q;
    if (tick_i) begin
      hist_d = {hist_q[HIST-2:0], smp_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  assign start_ok_o = tick_i & ~smp_i & (&hist_q);

endmodule

// File: rtl/rx_vote.sv
module rx_vote
  import serial_os_rx_pkg::*;
#(
  parameter int unsigned POS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             smp_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             vote_o,
  output logic             disagree_o,
  output logic             any_high_o,
  output logic             early_high_o
);

  localparam logic [POS_W-1:0] P_FIRST = POS_W'(1);
  localparam logic [POS_W-1:0] P_VA    = POS_W'(VOTE_A);
  localparam logic [POS_W-1:0] P_VB    = POS_W'(VOTE_B);
  localparam logic [POS_W-1:0] P_EA    = POS_W'(EARLY_A);
  localparam logic [POS_W-1:0] P_EB    = POS_W'(EARLY_B);
  localparam logic [POS_W-1:0] P_EC    = POS_W'(EARLY_C);

  logic va_q, va_d;
  logic vb_q, vb_d;
  logic early_q, early_d;
  logic is_early;

  assign is_early = (pos_i == P_EA) || (pos_i == P_EB) || (pos_i == P_EC);

  always_comb begin
    va_d    = va_q;
    vb_d    = vb_q;
    early_d = early_q;
    if (tick_i) begin
      if (pos_i == P_VA) begin
        va_d = smp_i;
      end
      if (pos_i == P_VB) begin
        vb_d = smp_i;
      end
      if (pos_i == P_FIRST) begin
        early_d = 1'b0;
      end else if (is_early) begin
        early_d = early_q | smp_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q    <= 1'b0;
      vb_q    <= 1'b0;
      early_q <= 1'b0;
    end else begin
      va_q    <= va_d;
      vb_q    <= vb_d;
      early_q <= early_d;
    end
  end

  // the third vote sample is the live one, valid at the last vote position
  assign vote_o       = (va_q & vb_q) | (va_q & smp_i) | (vb_q & smp_i);
  assign disagree_o   = !((va_q == vb_q) && (vb_q == smp_i));
  assign any_high_o   = va_q | vb_q | smp_i;
  assign early_high_o = early_q;

endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import serial_os_rx_pkg::*;
#(
  parameter int unsigned OSR       = 16,
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned POS_W     = 5,
  parameter int unsigned BIT_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 start_ok_i,
  input  logic                 vote_i,
  input  logic                 disagree_i,
  input  logic                 any_high_i,
  input  logic                 early_high_i,
  output logic [POS_W-1:0]     pos_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 noise_o,
  output logic                 frm_err_o
);

  localparam logic [POS_W-1:0] P_ONE  = POS_W'(1);
  localparam logic [POS_W-1:0] P_TWO  = POS_W'(2);
  localparam logic [POS_W-1:0] P_LAST = POS_W'(OSR);
  localparam logic [POS_W-1:0] P_VC   = POS_W'(VOTE_C);
  localparam logic [BIT_W-1:0] B_LAST = BIT_W'(DATA_BITS - 1);

  rx_state_e            st_q, st_d;
  logic [POS_W-1:0]     cnt_q, cnt_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [DATA_BITS-1:0] shreg_q, shreg_d;
  logic                 nacc_q, nacc_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 valid_q, valid_d;
  logic                 noise_q, noise_d;
  logic                 ferr_q, ferr_d;

  // next-state logic, enabled by the sample tick
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    shreg_d = shreg_q;
    nacc_d  = nacc_q;
    data_d  = data_q;
    valid_d = 1'b0;
    noise_d = noise_q;
    ferr_d  = ferr_q;
    if (tick_i) begin
      if (st_q == RX_IDLE) begin
        if (start_ok_i) begin
          st_d    = RX_START;
          cnt_d   = P_TWO;
          bit_d   = '0;
          nacc_d  = 1'b0;
          noise_d = 1'b0;
          ferr_d  = 1'b0;
        end
      end else begin
        cnt_d = (cnt_q == P_LAST) ? P_ONE : cnt_q + P_ONE;
        case (st_q)
          RX_START: begin
            if (cnt_q == P_VC) begin
              if (vote_i) begin
                st_d = RX_IDLE;
              end else begin
                nacc_d = early_high_i | any_high_i;
              end
            end else if (cnt_q == P_LAST) begin
              st_d = RX_DATA;
            end
          end
          RX_DATA: begin
            if (cnt_q == P_VC) begin
              shreg_d = (shreg_q >> 1) | (DATA_BITS'(vote_i) << (DATA_BITS - 1));
              nacc_d  = nacc_q | disagree_i;
            end else if (cnt_q == P_LAST) begin
              if (bit_q == B_LAST) begin
                st_d = RX_STOP;
              end else begin
                bit_d = bit_q + BIT_W'(1);
              end
            end
          end
          RX_STOP: begin
            if (cnt_q == P_VC) begin
              data_d  = shreg_q;
              valid_d = 1'b1;
              noise_d = nacc_q | disagree_i;
              ferr_d  = ~vote_i;
              st_d    = RX_IDLE;
            end
          end
          default: begin
            st_d = RX_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      cnt_q   <= P_ONE;
      bit_q   <= '0;
      shreg_q <= '0;
      nacc_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      noise_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      nacc_q  <= nacc_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      noise_q <= noise_d;
      ferr_q  <= ferr_d;
    end
  end

  // in idle the sample being taken would be number 1 of a start bit
  assign pos_o     = (st_q == RX_IDLE) ? P_ONE : cnt_q;
  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign noise_o   = noise_q;
  assign frm_err_o = ferr_q;

endmodule

// File: rtl/serial_os_rx.sv
module serial_os_rx #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HIST_LEN    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 noise_o,
  output logic                 frm_err_o
);

  localparam int unsigned POS_W = $clog2(OSR + 1);
  localparam int unsigned BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  logic             line_s;
  logic             start_ok;
  logic [POS_W-1:0] pos;
  logic             vote;
  logic             disagree;
  logic             any_high;
  logic             early_high;

  rx_sync2 #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  rx_edge_qual #(
    .HIST(HIST_LEN)
  ) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .smp_i     (line_s),
    .start_ok_o(start_ok)
  );

  rx_vote #(
    .POS_W(POS_W)
  ) u_vote (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .smp_i       (line_s),
    .pos_i       (pos),
    .vote_o      (vote),
    .disagree_o  (disagree),
    .any_high_o  (any_high),
    .early_high_o(early_high)
  );

  rx_ctrl #(
    .OSR      (OSR),
    .DATA_BITS(DATA_BITS),
    .POS_W    (POS_W),
    .BIT_W    (BIT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .start_ok_i  (start_ok),
    .vote_i      (vote),
    .disagree_i  (disagree),
    .any_high_i  (any_high),
    .early_high_i(early_high),
    .pos_o       (pos),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .noise_o     (noise_o),
    .frm_err_o   (frm_err_o)
  );

endmodule

// File: rtl/serial_os_rx_chk.sv
module serial_os_rx_chk #(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic [DATA_BITS-1:0] data_o,
  input logic                 valid_o,
  input logic                 noise_o,
  input logic                 frm_err_o
);

  // R9: strobe lasts one cycle
  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R12: strobe follows a tick edge
  assert_valid_after_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));

  // R9: noise flag only rises with the strobe
  assert_noise_with_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(noise_o) |-> valid_o);

  // R8: framing flag only rises with the strobe
  assert_ferr_with_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frm_err_o) |-> valid_o);

  // R1: byte output changes only with the strobe
  assert_data_with_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> valid_o);

  // R9: flags clear only on a tick (start acceptance)
  assert_noise_clear_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(noise_o) |-> $past(tick_i));

endmodule

bind serial_os_rx serial_os_rx_chk #(
  .DATA_BITS(DATA_BITS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .data_o   (data_o),
  .valid_o  (valid_o),
  .noise_o  (noise_o),
  .frm_err_o(frm_err_o)
);

// File: tb/serial_os_rx_bench.sv
`timescale 1ns/1ps
module serial_os_rx_bench;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       rxd;
  logic [7:0] data_o;
  logic       valid_o;
  logic       noise_o;
  logic       frm_err_o;
  logic [1:0] div_q;
  logic       valid_prev;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  serial_os_rx u_serial_os_rx (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .rxd_i    (rxd),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .noise_o  (noise_o),
    .frm_err_o(frm_err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // tick every fourth clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 2'd0;
    else        div_q <= div_q + 2'd1;
  end
  assign tick = (div_q == 2'd3);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] d, input logic n, input logic f,
                             input string tag);
    exp_q.push_back({f, n, d});
    tag_q.push_back(tag);
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o && valid_prev)
        chk(1'b0, "R9", "strobe longer than one cycle", 2, 1);
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7/R2", "unexpected strobe", 1, 0);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(data_o == e[7:0], t, "data", data_o, e[7:0]);
          chk(noise_o == e[8], t, "noise", noise_o, e[8]);
          chk(frm_err_o == e[9], t, "framing", frm_err_o, e[9]);
        end
      end
      valid_prev = valid_o;
    end else begin
      valid_prev = 1'b0;
    end
  end

  task automatic sync_tick();
    @(posedge clk iff tick);
    @(negedge clk);
  endtask

  // drive one value, seen by exactly the next tick sample
  task automatic drv(input logic v);
    rxd = v;
    @(posedge clk iff tick);
    @(negedge clk);
  endtask

  // pattern bit i is sample i+1
  task automatic drv_bit(input logic [15:0] pat);
    for (int i = 0; i < 16; i++) drv(pat[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(1'b1);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [15:0] spat,
                            input int nbit, input int nsmp,
                            input logic [15:0] stop_pat);
    drv_bit(spat);
    for (int k = 0; k < 8; k++) begin
      logic [15:0] p;
      p = {16{d[k]}};
      if (k == nbit) p[nsmp-1] = ~p[nsmp-1];
      drv_bit(p);
    end
    drv_bit(stop_pat);
  endtask

  // cycle-timed frame with an arbitrary bit length in clocks
  task automatic send_cyc(input logic [7:0] d, input int blen);
    @(negedge clk);
    rxd = 1'b0;
    repeat (blen) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxd = d[k];
      repeat (blen) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (blen * 3) @(negedge clk);
  endtask

  task automatic check_drained(input string req);
    chk(exp_q.size() == 0, req, "pending expected bytes", exp_q.size(), 0);
  endtask

  initial begin
    rxd   = 1'b0;
    rst_n = 1'b0;
    valid_prev = 1'b0;
    repeat (5) @(negedge clk);
    // R11: reset state
    chk(data_o == 8'h00, "R11", "data in reset", data_o, 0);
    chk({valid_o, noise_o, frm_err_o} == 3'b000, "R11", "flags in reset",
        {valid_o, noise_o, frm_err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({valid_o, noise_o, frm_err_o} == 3'b000, "R11", "flags after reset",
        {valid_o, noise_o, frm_err_o}, 0);

    // R2: only two high samples before the edge after reset -> rejected
    sync_tick();
    drv(1'b0); drv(1'b0); drv(1'b0);
    drv(1'b1); drv(1'b1);
    for (int i = 0; i < 9; i++) drv_bit(16'h0000);
    idle(20);
    check_drained("R2");
    chk(valid_prev == 1'b0 && data_o == 8'h00, "R2", "no byte from short idle",
        data_o, 0);

    // R1/R5: clean frame
    expect_byte(8'hA5, 1'b0, 1'b0, "R1/R5");
    send_frame(8'hA5, 16'h0000, -1, 0, 16'hFFFF);
    idle(4);
    check_drained("R1");

    // R6: data bit 2 sample 9 disturbed, value still voted
    expect_byte(8'h3C, 1'b1, 1'b0, "R6");
    send_frame(8'h3C, 16'h0000, 2, 9, 16'hFFFF);
    idle(4);
    // R5: sample 8 disturbed on bit 7
    expect_byte(8'h96, 1'b1, 1'b0, "R5");
    send_frame(8'h96, 16'h0000, 7, 8, 16'hFFFF);
    idle(4);
    // R9: flag cleared for the following clean frame
    expect_byte(8'h0F, 1'b0, 1'b0, "R9");
    send_frame(8'h0F, 16'h0000, -1, 0, 16'hFFFF);
    idle(4);

    // R3: start sample 5 high
    expect_byte(8'h81, 1'b1, 1'b0, "R3");
    send_frame(8'h81, 16'h0010, -1, 0, 16'hFFFF);
    idle(4);
    // R4: start sample 9 high, majority still low
    expect_byte(8'h5A, 1'b1, 1'b0, "R4");
    send_frame(8'h5A, 16'h0100, -1, 0, 16'hFFFF);
    idle(4);
    check_drained("R4");
    chk(noise_o == 1'b1, "R9", "noise held after strobe", noise_o, 1);

    // R7: start majority high -> dropped, noise cleared by acceptance
    drv_bit(16'hFF80);
    idle(20);
    check_drained("R7");
    chk(noise_o == 1'b0, "R9", "noise cleared at accepted start", noise_o, 0);
    expect_byte(8'hC6, 1'b0, 1'b0, "R7");
    send_frame(8'hC6, 16'h0000, -1, 0, 16'hFFFF);
    idle(4);

    // R8: stop bit low -> framing error with byte
    expect_byte(8'h77, 1'b0, 1'b1, "R8");
    send_frame(8'h77, 16'h0000, -1, 0, 16'h0000);
    idle(20);
    chk(frm_err_o == 1'b1, "R8", "framing flag held", frm_err_o, 1);
    expect_byte(8'h00, 1'b0, 1'b0, "R9");
    send_frame(8'h00, 16'h0000, -1, 0, 16'hFFFF);
    idle(4);
    // R8: stop sample 10 disturbed -> noise, no framing error
    expect_byte(8'hE1, 1'b1, 1'b0, "R8");
    send_frame(8'hE1, 16'h0000, -1, 0, 16'hFDFF);
    idle(4);

    // R9: back-to-back frames, one strobe each
    expect_byte(8'h12, 1'b0, 1'b0, "R9");
    expect_byte(8'h34, 1'b0, 1'b0, "R9");
    expect_byte(8'hFF, 1'b0, 1'b0, "R9");
    send_frame(8'h12, 16'h0000, -1, 0, 16'hFFFF);
    send_frame(8'h34, 16'h0000, -1, 0, 16'hFFFF);
    send_frame(8'hFF, 16'h0000, -1, 0, 16'hFFFF);
    idle(4);
    check_drained("R9");

    // R10/R12: rate mismatch, edges not aligned with ticks
    rxd = 1'b1;
    repeat (37) @(negedge clk);
    expect_byte(8'hC3, 1'b0, 1'b0, "R10");
    send_cyc(8'hC3, 62);
    expect_byte(8'h69, 1'b0, 1'b0, "R10");
    send_cyc(8'h69, 66);
    repeat (3) @(negedge clk);
    expect_byte(8'hB4, 1'b0, 1'b0, "R12");
    send_cyc(8'hB4, 64);
    repeat (40) @(negedge clk);
    check_drained("R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule